// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Write Protection

This block models a 256-byte non-volatile memory that answers as a target on a two-wire serial bus. SCL and SDA are oversampled by the system clock. The block finds START and STOP conditions and checks the device address. It acknowledges bytes by pulling SDA low through an output enable, and otherwise leaves the line released so other open-drain devices can share it. A bus master can write one or more bytes at a chosen location. It can read from a chosen location by sending a write-addressed header, a repeated START and a read header. It can also read from wherever the internal address counter points.

Writes pass through a protection check with two inputs. The first is a write-protect pin, which freezes the whole array. The second is a one-time lock flag, which freezes only the lower half, addresses 00h to 7Fh. A dedicated bus command sets the lock flag, and only a reset clears it. The device address is the type nibble 1010b followed by three strap inputs, so up to eight of these blocks can sit on one bus.

The protocol engine is a single state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_DEV`: shifts in the header byte.
- `ST_DACK`: acknowledges the header.
- `ST_LACK`: acknowledges the lock command.
- `ST_WADR`: shifts in the byte address.
- `ST_AACK`: acknowledges the byte address.
- `ST_WDAT`: shifts in a data byte.
- `ST_WACK`: acknowledges a data byte.
- `ST_RD`: shifts a byte out.
- `ST_RACK`: samples the master's acknowledge.

Its transitions are as follows:
- START from any state leads to `ST_DEV`, and STOP from any state leads to `ST_IDLE`.
- In `ST_DEV`, a memory header goes to `ST_DACK`, a lock command goes to `ST_LACK`, and anything else goes to `ST_IDLE`.
- `ST_DACK` goes to `ST_RD` for a read and to `ST_WADR` for a write.
- `ST_LACK` goes to `ST_IDLE`.
- The write path runs `ST_WADR` to `ST_AACK` to `ST_WDAT` to `ST_WACK`, and `ST_WACK` returns to `ST_WDAT`.
- `ST_RD` goes to `ST_RACK`. `ST_RACK` returns to `ST_RD` when the master acknowledges and goes to `ST_IDLE` when it does not.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every byte of the array reads FFh, the address counter is 00h and the lock flag is clear.
- R2: A header whose upper nibble is 1010b and whose bits 3..1 equal `strap_i` is acknowledged. Bit 0 of the header selects read (1) or write (0). A header with a different type nibble or different strap bits gets no acknowledge and changes nothing.
- R3: In a write, the header, the byte address and each data byte are acknowledged. Each data byte is stored at the counter, and the counter then advances by one.
- R4: A read returns the byte at the counter and then advances the counter. While the master acknowledges, reading continues sequentially, and the counter wraps from FFh to 00h.
- R5: A read header that has no address phase before it starts at the current counter value.
- R6: While `wp_i` is 1, no write changes the array, whatever the lock flag. The data bytes are still acknowledged.
- R7: A header 0110b plus the strap bits plus write bit 0 sets the lock flag and is acknowledged. While the flag is set and `wp_i` is 0, writes to 00h..7Fh are acknowledged but leave the array unchanged, and writes to 80h..FFh take effect.
- R8: While the lock flag is set, the lock command gets no acknowledge. Only a reset clears the flag.
- R9: A STOP or repeated START before the eighth bit of a data byte aborts that byte without a write, and a repeated START begins a new header.
- R10: `sda_oe` changes only while SCL is low, except in the cycle after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Resolved level of the serial data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Strapped low bits of the device address |
| wp_i | input | 1 | Write protect, 1 blocks every write |

## Verification
If the bit counter or the state slips, the acknowledge moves into a data bit. The master then sees a missing acknowledge, or a corrupted byte, within the same nine-clock frame. If the counter or the protection decision goes wrong, nothing shows on the bus at the time of the write. It appears only on the next read of that location, so every write is followed by a read-back through the bus. The lock flag has no visible output. It is observed through whether a lower-half write sticks and through the acknowledge given to a second lock command.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DACK, ST_LACK, ST_WADR,
        ST_AACK, ST_WDAT, ST_WACK, ST_RD, ST_RACK
    } eep_state_t;

    localparam int          FRAME_W   = 8;
    localparam logic [3:0]  TYPE_MEM  = 4'b1010;
    localparam logic [3:0]  TYPE_LOCK = 4'b0110;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_wr_guard.sv
module eep_wr_guard #(
    parameter int AW = 8
) (
    input  logic          wp,
    input  logic          locked,
    input  logic [AW-1:0] addr,
    output logic          allow
);
    logic lower_half;
    assign lower_half = ~addr[AW-1];
    assign allow      = ~wp & ~(locked & lower_half);
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int            AW   = 8,
    parameter int            DW   = 8,
    parameter logic [DW-1:0] FILL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= FILL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam logic [3:0] LAST_BIT = 4'(FRAME_W);

    eep_state_t          state_q;
    logic [3:0]          bitcnt_q;
    logic [FRAME_W-1:0]  rx_q, tx_q;
    logic [AW-1:0]       cnt_q;
    logic                lock_q, rw_q, mack_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_ok, mem_we, byte_done;
    logic [FRAME_W-1:0] rdata;
    logic hdr_strap_ok;

    eep_bus_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    eep_wr_guard #(.AW(AW)) u_guard (
        .wp(wp_i), .locked(lock_q), .addr(cnt_q), .allow(wr_ok)
    );

    eep_mem #(.AW(AW), .DW(FRAME_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(cnt_q),
        .wdata(rx_q), .raddr(cnt_q), .rdata(rdata)
    );

    assign byte_done    = scl_fall && (bitcnt_q == LAST_BIT);
    assign hdr_strap_ok = (rx_q[3:1] == strap_i);
    assign mem_we       = (state_q == ST_WDAT) && byte_done && wr_ok;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            cnt_q    <= '0;
            lock_q   <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b1;
        end else if (start_ev) begin
            state_q  <= ST_DEV;
            bitcnt_q <= '0;
        end else if (stop_ev) begin
            state_q  <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise && bitcnt_q != LAST_BIT) begin
                        rx_q     <= {rx_q[FRAME_W-2:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_DEV) begin
                            if (rx_q[7:4] == TYPE_MEM && hdr_strap_ok) begin
                                state_q <= ST_DACK;
                                rw_q    <= rx_q[0];
                            end else if (rx_q[7:4] == TYPE_LOCK && hdr_strap_ok
                                         && !rx_q[0] && !lock_q) begin
                                state_q <= ST_LACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else if (state_q == ST_WADR) begin
                            cnt_q   <= AW'(rx_q);
                            state_q <= ST_AACK;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= ST_WACK;
                        end
                    end
                end
                ST_DACK: if (scl_fall) begin
                    if (rw_q) begin
                        state_q  <= ST_RD;
                        tx_q     <= rdata;
                        bitcnt_q <= '0;
                    end else begin
                        state_q  <= ST_WADR;
                    end
                end
                ST_LACK: if (scl_fall) begin
                    lock_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_AACK, ST_WACK: if (scl_fall) state_q <= ST_WDAT;
                ST_RD: if (scl_fall) begin
                    if (bitcnt_q == LAST_BIT - 4'd1) begin
                        state_q  <= ST_RACK;
                        cnt_q    <= cnt_q + 1'b1;
                        bitcnt_q <= '0;
                    end else begin
                        tx_q     <= {tx_q[FRAME_W-2:0], 1'b0};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= sda_s;
                    if (scl_fall) begin
                        if (!mack_q) begin
                            state_q <= ST_RD;
                            tx_q    <= rdata;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        sda_oe = 1'b0;
        unique case (state_q)
            ST_DACK, ST_LACK, ST_AACK, ST_WACK: sda_oe = 1'b1;
            ST_RD:                              sda_oe = ~tx_q[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    assert_hdr_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DACK) |-> (rx_q[7:4] == TYPE_MEM && rx_q[3:1] == strap_i));

    assert_rd_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RD && state_q == ST_RACK) |-> (cnt_q == AW'($past(cnt_q) + 1'b1)));

    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_i);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> lock_q);

    assert_no_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LACK) |-> !lock_q);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !scl_s);
endmodule

// File: tb/eep_i2c_target_test.sv
`timescale 1ns/100ps
module eep_i2c_target_test;
    localparam int Q = 6;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] HW  = 8'hAA;   // 1010_101_0
    localparam logic [7:0] HR  = 8'hAB;   // 1010_101_1
    localparam logic [7:0] HL  = 8'h6A;   // 0110_101_0
    // {wp, addr, data, expected read-back}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 8'h10, 8'hA5, 8'hA5},
        {1'b1, 8'h10, 8'h3C, 8'hA5},
        {1'b0, 8'h80, 8'h5A, 8'h5A},
        {1'b0, 8'h7F, 8'h11, 8'h11},
        {1'b1, 8'h80, 8'h22, 8'h5A},
        {1'b0, 8'hFF, 8'hC3, 8'hC3}
    };

    logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1, wp = 0;
    logic sda_oe, sda_line;
    int nvec = 0, nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    eep_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1; tick(Q); m_scl = 1; tick(Q); b = sda_line; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        send_bit(nack);
    endtask

    task automatic write_at(input logic [7:0] a, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start(); send_byte(HW, a0); send_byte(a, a1); send_byte(d, a2); bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] v);
        logic a0, a1, a2;
        bus_start(); send_byte(HW, a0); send_byte(a, a1);
        bus_start(); send_byte(HR, a2); get_byte(1'b1, v); bus_stop();
        check("R4 header acks", {5'b0, a0, a1, a2}, 8'h07);
    endtask

    task automatic read_cur(output logic [7:0] v);
        logic a0;
        bus_start(); send_byte(HR, a0); get_byte(1'b1, v); bus_stop();
        check("R5 header ack", {7'b0, a0}, 8'h01);
    endtask

    task automatic lock_cmd(output logic ack);
        bus_start(); send_byte(HL, ack); bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++; nvec++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic ok, ack;
        tick(4); rst_n = 1; tick(4);

        check("R1 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
        read_cur(v);
        check("R1 erased byte via counter 00h (R5)", v, 8'hFF);

        for (int i = 0; i < 6; i++) begin
            automatic logic [24:0] e = VEC[i];
            wp = e[24];
            write_at(e[23:16], e[15:8], ok);
            check("R3/R6 write acked", {7'b0, ok}, 8'h01);
            wp = 0;
            read_at(e[23:16], v);
            check(e[24] ? "R6 wp blocks write" : "R3 byte stored", v, e[7:0]);
        end

        // counter after write (R3)
        write_at(8'h21, 8'h32, ok);
        write_at(8'h20, 8'h31, ok);
        read_cur(v);
        check("R3 counter advanced after write", v, 8'h32);

        // sequential read with wrap (R4), then current-address (R5)
        write_at(8'h00, 8'h77, ok);
        write_at(8'h01, 8'h99, ok);
        write_at(8'h02, 8'h44, ok);
        begin
            logic a0, a1, a2;
            bus_start(); send_byte(HW, a0); send_byte(8'hFF, a1);
            bus_start(); send_byte(HR, a2);
            get_byte(1'b0, v); check("R4 seq byte FFh", v, 8'hC3);
            get_byte(1'b0, v); check("R4 wrap to 00h", v, 8'h77);
            get_byte(1'b1, v); check("R4 seq byte 01h", v, 8'h99);
            bus_stop();
        end
        read_cur(v);
        check("R5 current-address read", v, 8'h44);

        // strap / type mismatch (R2)
        begin
            logic a0, a1, a2;
            bus_start(); send_byte(8'hA8, a0); send_byte(8'h30, a1); send_byte(8'h55, a2); bus_stop();
            check("R2 strap mismatch nack", {7'b0, a0}, 8'h00);
            bus_start(); send_byte(8'hBA, a0); bus_stop();
            check("R2 type mismatch nack", {7'b0, a0}, 8'h00);
        end
        read_at(8'h30, v);
        check("R2 mismatch leaves array", v, 8'hFF);

        // aborted data byte (R9)
        begin
            logic a0, a1;
            bus_start(); send_byte(HW, a0); send_byte(8'h40, a1);
            for (int i = 0; i < 4; i++) send_bit(1'b0);
            bus_stop();
            read_at(8'h40, v);
            check("R9 stop aborts byte", v, 8'hFF);
            bus_start(); send_byte(HW, a0); send_byte(8'h41, a1);
            for (int i = 0; i < 3; i++) send_bit(1'b0);
            bus_start(); send_byte(HR, a0);
            check("R9 restart header acked", {7'b0, a0}, 8'h01);
            get_byte(1'b1, v); bus_stop();
            check("R9 restart aborts byte", v, 8'hFF);
        end

        // lock (R7, R8)
        lock_cmd(ack);
        check("R7 lock command acked", {7'b0, ack}, 8'h01);
        write_at(8'h10, 8'h00, ok);
        check("R7 locked write acked", {7'b0, ok}, 8'h01);
        read_at(8'h10, v);
        check("R7 lower half locked", v, 8'hA5);
        write_at(8'h90, 8'h66, ok);
        read_at(8'h90, v);
        check("R7 upper half writable", v, 8'h66);
        lock_cmd(ack);
        check("R8 relock nacked", {7'b0, ack}, 8'h00);
        wp = 1;
        write_at(8'h90, 8'h01, ok);
        wp = 0;
        read_at(8'h90, v);
        check("R6 wp with lock", v, 8'h66);

        // reset clears everything (R1, R8)
        rst_n = 0; tick(4); rst_n = 1; tick(4);
        check("R1 sda_oe after second reset", {7'b0, sda_oe}, 8'h00);
        read_at(8'h90, v);
        check("R1 array erased by reset", v, 8'hFF);
        write_at(8'h10, 8'h5E, ok);
        read_at(8'h10, v);
        check("R8 reset clears lock", v, 8'h5E);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule